// File: doc/BRIEF.md
# Execution Pipeline Sleep Controller

This block decides when one execution pipeline (integer or floating point) may be switched off to cut leakage, and when it must be brought back. Each cycle it samples whether the pipeline is busy, whether an instruction for it is waiting, and how many active warps still need this unit type. The unit is put to sleep after a run of idle cycles. Once asleep it is held off for a fixed breakeven window, even if work arrives, so that each sleep pays back its own overhead. Waking takes a fixed number of cycles. The integer and floating-point pipelines each use their own instance, so each keeps its own threshold.

The idle-detect threshold adapts. A wake request that falls on the last cycle of a breakeven window counts as a critical wakeup, a sign that forced sleep is costing performance. At each epoch boundary the threshold rises when such events were frequent. It also falls back by one at a slower fixed cadence. `unit_ready` is the back-pressure signal of the issue side: an instruction may go to the pipeline only in a cycle where `unit_ready` is high. `inst_pending` is the matching valid signal. A waiting instruction does not force a wake during the breakeven window. The other pins are plain level controls.

Top module: `pgate_ctrl`

## Requirements
- R1: After reset the unit is on: `unit_ready`=1, `sleep_req`=0, `wake_req`=0, and `idle_limit` equals 5.
- R2: While on, a cycle with `unit_busy` or `inst_pending` high is not idle and clears the idle run. The unit stays on with `unit_ready`=1 while such cycles continue.
- R3: While on, the rising edge that ends the `idle_limit`-th consecutive idle cycle moves the unit into blackout: `sleep_req`=1 and `unit_ready`=0 from then on.
- R4: With coordinated gating (the default), the unit is never put to sleep while `active_warps` is non-zero, however long it has been idle.
- R5: Blackout lasts exactly 14 cycles whatever `inst_pending` does. If `inst_pending` is high in the last blackout cycle, the unit goes straight to waking. Otherwise it stays asleep (`sleep_req`=1).
- R6: After blackout the unit stays asleep until `inst_pending` is seen, and waking starts on the next edge.
- R7: Waking drives `wake_req`=1, `sleep_req`=0 and `unit_ready`=0 for exactly 3 cycles, then the unit is on with `unit_ready`=1.
- R8: Epochs are 1000 cycles long. An epoch ends on every 1000th rising edge after reset release. If more than 2 critical wakeups (R5 last-cycle wakes) fell in that epoch, `idle_limit` rises by one on that edge. The count then restarts. Between epoch ends `idle_limit` is constant.
- R9: Every 4th epoch end lowers `idle_limit` by one. When a rise and a fall fall on the same edge, the value is unchanged.
- R10: `idle_limit` never leaves the range 5 to 10. A step beyond either bound is dropped.
- R11: A changed `idle_limit` is used by the very next idle run. For example, with a limit of 6, five idle cycles keep the unit on and the sixth puts it to sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_busy | input | 1 | Pipeline is executing this cycle |
| inst_pending | input | 1 | An instruction for this pipeline is waiting (valid) |
| active_warps | input | WARP_W (6) | Active warps that still need this unit type |
| sleep_req | output | 1 | Power switch off request |
| wake_req | output | 1 | Power-up in progress |
| unit_ready | output | 1 | Pipeline may accept an instruction (ready) |
| idle_limit | output | LIM_W (4) | Current idle-detect threshold |

## Verification
The hardest situation to reach is a threshold change. It needs more than two wakes that land exactly on the closing cycle of blackout, all inside one 1000-cycle window, and then a long quiet stretch to see the slow decay and the lower bound. The stimulus creates each critical wake by raising `inst_pending` as soon as `sleep_req` appears. It holds the request through the whole window and keeps the unit busy between bursts, so no stray sleep adds extra events. A bench cycle count then places each check just after an epoch edge, and the bursts are repeated until the upper bound is reached and an increment lands on a decay edge.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_ON       = 2'd0,
    PG_BLACKOUT = 2'd1,
    PG_GATED    = 2'd2,
    PG_WAKING   = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pg_idle_counter.sv
module pg_idle_counter #(
  parameter int LIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_on,
  input  logic             idle,
  input  logic [LIM_W-1:0] limit,
  output logic             gate_ok
);
  logic [LIM_W-1:0] run_cnt;
  logic [LIM_W:0]   run_next;

  always_ff @(posedge clk) begin
    if (!rst_n)               run_cnt <= '0;
    else if (!in_on || !idle) run_cnt <= '0;
    else if (run_cnt != '1)   run_cnt <= run_cnt + LIM_W'(1);
  end

  assign run_next = {1'b0, run_cnt} + (LIM_W+1)'(1);
  assign gate_ok  = in_on && idle && (run_next >= {1'b0, limit});

  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_on && !idle) |=> (run_cnt == '0)); // R2
endmodule

// File: rtl/pg_fsm.sv
module pg_fsm
  import pg_pkg::*;
#(
  parameter int BREAKEVEN   = 14,
  parameter int WAKE_CYC    = 3,
  parameter int WARP_W      = 6,
  parameter bit COORDINATED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_ok,
  input  logic              inst_pending,
  input  logic [WARP_W-1:0] active_warps,
  output logic              in_on,
  output logic              crit_pulse,
  output logic              sleep_req,
  output logic              wake_req,
  output logic              unit_ready
);
  localparam int TMR_MAX = (BREAKEVEN > WAKE_CYC) ? BREAKEVEN : WAKE_CYC;
  localparam int TMR_W   = (TMR_MAX > 2) ? $clog2(TMR_MAX) : 1;
  localparam logic [TMR_W-1:0] BO_LAST = TMR_W'(BREAKEVEN - 1);
  localparam logic [TMR_W-1:0] WK_LAST = TMR_W'(WAKE_CYC - 1);

  pg_state_e        state, state_nx;
  logic [TMR_W-1:0] tmr;
  logic             warps_ok;

  generate
    if (COORDINATED) begin : g_coord
      assign warps_ok = (active_warps == '0);
    end else begin : g_free
      assign warps_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    state_nx = state;
    case (state)
      PG_ON:       if (gate_ok && warps_ok) state_nx = PG_BLACKOUT;
      PG_BLACKOUT: if (tmr == BO_LAST) state_nx = inst_pending ? PG_WAKING : PG_GATED;
      PG_GATED:    if (inst_pending) state_nx = PG_WAKING;
      PG_WAKING:   if (tmr == WK_LAST) state_nx = PG_ON;
      default:     state_nx = PG_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PG_ON;
      tmr   <= '0;
    end else begin
      state <= state_nx;
      if (state_nx != state) tmr <= '0;
      else if (tmr != '1)    tmr <= tmr + TMR_W'(1);
    end
  end

  assign in_on      = (state == PG_ON);
  assign unit_ready = (state == PG_ON);
  assign sleep_req  = (state == PG_BLACKOUT) || (state == PG_GATED);
  assign wake_req   = (state == PG_WAKING);
  assign crit_pulse = (state == PG_BLACKOUT) && (tmr == BO_LAST) && inst_pending;

  AST_SLEEP_FROM_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req) |-> $past(unit_ready)); // R3
  AST_BLACKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_BLACKOUT && tmr != BO_LAST) |=> sleep_req); // R5
  AST_WAKE_TO_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_req) |-> unit_ready); // R7
  AST_COORD_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (COORDINATED && unit_ready && active_warps != '0) |=> !sleep_req); // R4
  AST_BUSY_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_ready && !gate_ok) |=> unit_ready); // R2
endmodule

// File: rtl/pg_adapt.sv
module pg_adapt #(
  parameter int EPOCH_LEN    = 1000,
  parameter int DECAY_EPOCHS = 4,
  parameter int CRIT_THRESH  = 2,
  parameter int IDLE_MIN     = 5,
  parameter int IDLE_MAX     = 10,
  parameter int IDLE_INIT    = 5,
  parameter int LIM_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crit_pulse,
  output logic [LIM_W-1:0] limit
);
  localparam int EW = (EPOCH_LEN > 2) ? $clog2(EPOCH_LEN) : 1;
  localparam int CW = $clog2(EPOCH_LEN + 1);
  localparam int DW = (DECAY_EPOCHS > 2) ? $clog2(DECAY_EPOCHS) : 1;
  localparam logic [EW-1:0]    EP_LAST  = EW'(EPOCH_LEN - 1);
  localparam logic [DW-1:0]    DEC_LAST = DW'(DECAY_EPOCHS - 1);
  localparam logic [CW-1:0]    THR      = CW'(CRIT_THRESH);
  localparam logic [LIM_W-1:0] MIN_L    = LIM_W'(IDLE_MIN);
  localparam logic [LIM_W-1:0] MAX_L    = LIM_W'(IDLE_MAX);
  localparam logic [LIM_W-1:0] INIT_L   = LIM_W'(IDLE_INIT);

  logic [EW-1:0]    ep_cnt;
  logic [CW-1:0]    crit_cnt, crit_total;
  logic [DW-1:0]    dec_cnt;
  logic             epoch_end, inc_now, dec_now;
  logic [LIM_W-1:0] lim_nx;

  assign epoch_end  = (ep_cnt == EP_LAST);
  assign crit_total = crit_cnt + CW'(crit_pulse);
  assign inc_now    = epoch_end && (crit_total > THR);
  assign dec_now    = epoch_end && (dec_cnt == DEC_LAST);

  always_comb begin
    lim_nx = limit;
    if (inc_now && !dec_now && limit < MAX_L)      lim_nx = limit + LIM_W'(1);
    else if (dec_now && !inc_now && limit > MIN_L) lim_nx = limit - LIM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_cnt   <= '0;
      crit_cnt <= '0;
      dec_cnt  <= '0;
      limit    <= INIT_L;
    end else begin
      limit <= lim_nx;
      if (epoch_end) begin
        ep_cnt   <= '0;
        crit_cnt <= '0;
        dec_cnt  <= dec_now ? '0 : dec_cnt + DW'(1);
      end else begin
        ep_cnt   <= ep_cnt + EW'(1);
        crit_cnt <= crit_total;
      end
    end
  end

  AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (limit >= MIN_L) && (limit <= MAX_L)); // R10
  AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_end |=> $stable(limit)); // R8
  AST_LIMIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_end |=> (limit == $past(limit) || limit == $past(limit) + LIM_W'(1)
                   || limit == $past(limit) - LIM_W'(1))); // R9
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl #(
  parameter int BREAKEVEN    = 14,
  parameter int WAKE_CYC     = 3,
  parameter int EPOCH_LEN    = 1000,
  parameter int DECAY_EPOCHS = 4,
  parameter int CRIT_THRESH  = 2,
  parameter int IDLE_MIN     = 5,
  parameter int IDLE_MAX     = 10,
  parameter int IDLE_INIT    = 5,
  parameter int WARP_W       = 6,
  parameter bit COORDINATED  = 1'b1,
  localparam int LIM_W       = $clog2(IDLE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_busy,
  input  logic              inst_pending,
  input  logic [WARP_W-1:0] active_warps,
  output logic              sleep_req,
  output logic              wake_req,
  output logic              unit_ready,
  output logic [LIM_W-1:0]  idle_limit
);
  logic in_on, gate_ok, crit_pulse, idle;

  assign idle = !unit_busy && !inst_pending;

  pg_idle_counter #(.LIM_W(LIM_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .in_on(in_on), .idle(idle),
    .limit(idle_limit), .gate_ok(gate_ok)
  );

  pg_fsm #(
    .BREAKEVEN(BREAKEVEN), .WAKE_CYC(WAKE_CYC),
    .WARP_W(WARP_W), .COORDINATED(COORDINATED)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .gate_ok(gate_ok), .inst_pending(inst_pending),
    .active_warps(active_warps), .in_on(in_on), .crit_pulse(crit_pulse),
    .sleep_req(sleep_req), .wake_req(wake_req), .unit_ready(unit_ready)
  );

  pg_adapt #(
    .EPOCH_LEN(EPOCH_LEN), .DECAY_EPOCHS(DECAY_EPOCHS), .CRIT_THRESH(CRIT_THRESH),
    .IDLE_MIN(IDLE_MIN), .IDLE_MAX(IDLE_MAX), .IDLE_INIT(IDLE_INIT), .LIM_W(LIM_W)
  ) u_adapt (
    .clk(clk), .rst_n(rst_n), .crit_pulse(crit_pulse), .limit(idle_limit)
  );

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unit_ready, sleep_req, wake_req})); // R7
endmodule

// File: tb/tb_pgate_ctrl.sv
module tb_pgate_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       unit_busy = 1'b0;
  logic       inst_pending = 1'b0;
  logic [5:0] active_warps = '0;
  logic       sleep_req, wake_req, unit_ready;
  logic [3:0] idle_limit;
  int         total = 0;
  int         bad = 0;
  int         cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  pgate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .unit_busy(unit_busy), .inst_pending(inst_pending),
    .active_warps(active_warps), .sleep_req(sleep_req), .wake_req(wake_req),
    .unit_ready(unit_ready), .idle_limit(idle_limit)
  );

  // {busy, pending, warps[5:0], edges[7:0], exp ready, exp sleep, exp wake}
  localparam logic [18:0] VEC [16] = '{
    {1'b1, 1'b0, 6'd0, 8'd3,  3'b100},
    {1'b0, 1'b0, 6'd3, 8'd10, 3'b100},
    {1'b1, 1'b0, 6'd0, 8'd1,  3'b100},
    {1'b0, 1'b0, 6'd0, 8'd4,  3'b100},
    {1'b0, 1'b0, 6'd0, 8'd1,  3'b010},
    {1'b0, 1'b1, 6'd0, 8'd12, 3'b010},
    {1'b0, 1'b1, 6'd0, 8'd1,  3'b010},
    {1'b0, 1'b1, 6'd0, 8'd1,  3'b001},
    {1'b0, 1'b1, 6'd0, 8'd2,  3'b001},
    {1'b0, 1'b1, 6'd0, 8'd1,  3'b100},
    {1'b0, 1'b0, 6'd0, 8'd5,  3'b010},
    {1'b0, 1'b0, 6'd0, 8'd13, 3'b010},
    {1'b0, 1'b0, 6'd0, 8'd1,  3'b010},
    {1'b0, 1'b0, 6'd0, 8'd20, 3'b010},
    {1'b0, 1'b1, 6'd0, 8'd1,  3'b001},
    {1'b0, 1'b1, 6'd0, 8'd3,  3'b100}
  };

  function automatic string req_of(int i);
    case (i)
      0, 2:          return "R2 busy keeps on";
      1:             return "R4 warps block gating";
      3, 4, 10:      return "R3 idle run gates";
      5, 6, 11:      return "R5 blackout holds";
      7:             return "R5 last-cycle wake";
      8, 9, 15:      return "R7 wake length";
      12, 13:        return "R6 stays gated";
      default:       return "R6 pending wakes";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_lim(input int exp, input string req);
    check(idle_limit == 4'(exp), req, int'(idle_limit), exp);
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic crit_burst();
    unit_busy = 1'b0; inst_pending = 1'b0; active_warps = '0;
    for (int k = 0; k < 40 && !sleep_req; k++) @(negedge clk);
    check(sleep_req == 1'b1, "R3 burst sleep", int'(sleep_req), 1);
    inst_pending = 1'b1;
    for (int k = 0; k < 40 && !unit_ready; k++) @(negedge clk);
    check(unit_ready == 1'b1, "R7 burst return", int'(unit_ready), 1);
    unit_busy = 1'b1; inst_pending = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check({unit_ready, sleep_req, wake_req} == 3'b100, "R1 reset outputs",
          int'({unit_ready, sleep_req, wake_req}), 4);
    check_lim(5, "R1 reset limit");

    for (int i = 0; i < 16; i++) begin
      unit_busy    = VEC[i][18];
      inst_pending = VEC[i][17];
      active_warps = VEC[i][16:11];
      repeat (int'(VEC[i][10:3])) @(posedge clk);
      @(negedge clk);
      check({unit_ready, sleep_req, wake_req} == VEC[i][2:0], req_of(i),
            int'({unit_ready, sleep_req, wake_req}), int'(VEC[i][2:0]));
    end

    // one critical wake already in epoch 0; two more make three (> 2)
    unit_busy = 1'b1; inst_pending = 1'b0;
    @(negedge clk);
    crit_burst();
    crit_burst();
    check_lim(5, "R8 no change mid-epoch");
    wait_cyc(1000);
    check_lim(6, "R8 rise after epoch 0");

    // R11 new limit governs gating: 5 idle edges stay on, 6th sleeps
    unit_busy = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(unit_ready == 1'b1, "R11 still on at 5 idle", int'(unit_ready), 1);
    @(posedge clk);
    @(negedge clk);
    check(sleep_req == 1'b1, "R11 sleeps at 6 idle", int'(sleep_req), 1);
    inst_pending = 1'b1;
    for (int k = 0; k < 40 && !unit_ready; k++) @(negedge clk);
    unit_busy = 1'b1; inst_pending = 1'b0;
    @(negedge clk);
    crit_burst();
    crit_burst();
    wait_cyc(2000);
    check_lim(7, "R8 rise after epoch 1");

    for (int e = 3; e <= 7; e++) begin
      crit_burst(); crit_burst(); crit_burst();
      wait_cyc(e * 1000);
      case (e)
        3: check_lim(8, "R8 rise after epoch 2");
        4: check_lim(8, "R9 rise and decay cancel");
        5: check_lim(9, "R8 rise after epoch 4");
        6: check_lim(10, "R10 reach max");
        default: check_lim(10, "R10 clamp at max");
      endcase
    end

    // quiet from here: only decay every 4th epoch
    wait_cyc(8000);
    check_lim(9, "R9 decay at epoch 8");
    wait_cyc(12000);
    check_lim(8, "R9 decay at epoch 12");
    wait_cyc(24000);
    check_lim(5, "R9 decay reaches min");
    wait_cyc(28000);
    check_lim(5, "R10 clamp at min");
    check(unit_ready == 1'b1, "R2 busy held on", int'(unit_ready), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule